// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block is the digital control front end for a five-bit, binary-weighted step attenuator with 1 dB per LSB. Five parallel control bits, a latch-enable input and a two-bit power-up select enter through two-flop synchronizers. The block drives a registered attenuation code, plus the same value reported in whole dB. The level of the enable picks the mode. While the enable is high, the output is transparent and follows the control bits. While it is low, the output holds. A high pulse followed by a return to low leaves the output holding the control word that was sampled in the last high cycle.

After reset the block waits until the synchronizers are filled, then loads a known starting state. If the enable is low at that moment, the power-up select chooses the state. If the enable is high, normal transparent operation starts at once.

The block also checks the control timing in sampling-clock cycles. It checks the minimum width of the enable pulse, how long the data was stable before the enable rose, and how long the data stays stable after the enable falls. Each of the three rules has its own sticky flag. A flag is cleared by reset or by a one-cycle clear pulse.

Top module: `attn_ctrl_latch`

## Requirements
- R1: While rst_n is low, atten_q, atten_db and all three error flags are 0.
- R2: While the synchronized enable is low after start-up, changes on ctl_in leave atten_q unchanged.
- R3: While the enable is high, atten_q follows ctl_in. A change driven just after a clock edge appears on atten_q after the third following rising edge (SYNC_STAGES+1 edges).
- R4: After the enable returns low, atten_q keeps the ctl_in value of the last cycle in which the enable was sampled high. Bit 4 weighs 16 dB, bit 3 8 dB, bit 2 4 dB, bit 1 2 dB and bit 0 1 dB. atten_db equals the binary value of atten_q.
- R5: If the enable is low when reset is released, the starting state comes from psel: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 31, and 2'b11 gives ctl_in.
- R6: If the enable is high when reset is released, psel has no effect and atten_q takes ctl_in.
- R7: err_pulse is set when the enable falls after fewer than PW_MIN sampled high cycles.
- R8: err_setup is set when the enable rises fewer than SETUP_MIN cycles after the last change of ctl_in. Exactly SETUP_MIN cycles is legal.
- R9: err_hold is set when ctl_in changes fewer than HOLD_MIN cycles after the enable falls. Exactly HOLD_MIN cycles is legal.
- R10: The error flags stay set until reset or until a cycle with clr_flags high. When a new violation and clr_flags fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_in | input | 5 | Parallel attenuation control word, bit 4 = 16 dB |
| le_in | input | 1 | Latch enable: high is transparent, low holds |
| psel | input | 2 | Power-up state select |
| clr_flags | input | 1 | Clears the error flags when high for one cycle |
| atten_q | output | 5 | Registered attenuation state |
| atten_db | output | 5 | Current attenuation in whole dB |
| err_pulse | output | 1 | Sticky flag: enable pulse too short |
| err_setup | output | 1 | Sticky flag: data changed too close before the enable rose |
| err_hold | output | 1 | Sticky flag: data changed too soon after the enable fell |

## Verification
The sticky-flag clear and a freshly detected hold violation can land on the same clock edge. To provoke this, the bench changes the control word one cycle after the enable falls. It then counts the synchronizer and detection registers and raises clr_flags for exactly the edge on which the hold flag is written. The flag must read 1 afterwards, and a later clear on its own must bring it to 0. The legal boundaries (setup and hold of exactly the minimum, and a pulse of exactly the minimum width) are run next to the one-cycle-short cases, and the bench judges which flag, if any, is raised.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam int unsigned ATTN_W = 5;
  typedef logic [ATTN_W-1:0] attn_t;

  // starting state chosen by the power-up select when the enable is low
  function automatic attn_t power_up_state(input logic [1:0] sel, input attn_t ctl);
    case (sel)
      2'b00:   return attn_t'(8);
      2'b01:   return attn_t'(16);
      2'b10:   return attn_t'(31);
      default: return ctl;
    endcase
  endfunction

  // whole-dB value from the binary weights of the state bits
  function automatic attn_t to_db(input attn_t st);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < ATTN_W; i++) begin
      if (st[i]) acc += (1 << i);
    end
    return attn_t'(acc);
  endfunction
endpackage

// File: rtl/attn_sync.sv
module attn_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/attn_state.sv
module attn_state
  import attn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       le_s,
  input  attn_t      ctl_s,
  input  logic [1:0] psel_s,
  output attn_t      state_q,
  output logic       rdy
);
  localparam int unsigned RC_W = $clog2(SYNC_STAGES + 2);
  localparam logic [RC_W-1:0] FIRE_AT = RC_W'(SYNC_STAGES);
  localparam logic [RC_W-1:0] READY_AT = RC_W'(SYNC_STAGES + 1);

  logic [RC_W-1:0] rcnt;
  logic            init_fire;

  assign init_fire = (rcnt == FIRE_AT);
  assign rdy       = (rcnt == READY_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt    <= '0;
      state_q <= '0;
    end else begin
      if (!rdy) rcnt <= rcnt + 1'b1;
      if (init_fire)
        state_q <= le_s ? ctl_s : power_up_state(psel_s, ctl_s);
      else if (rdy && le_s)
        state_q <= ctl_s;
    end
  end

  a_r2_hold_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !le_s) |=> $stable(state_q));
  a_r3_follow_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && le_s) |=> (state_q == $past(ctl_s)));
endmodule

// File: rtl/attn_timing.sv
module attn_timing #(
  parameter int unsigned PW_MIN    = 1,
  parameter int unsigned SETUP_MIN = 1,
  parameter int unsigned HOLD_MIN  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  input  logic le_s,
  input  logic le_rise,
  input  logic le_fall,
  input  logic ctl_chg,
  input  logic clr,
  output logic err_pulse,
  output logic err_setup,
  output logic err_hold
);
  localparam int unsigned PW_CW = $clog2(PW_MIN + 2);
  localparam int unsigned SU_CW = $clog2(SETUP_MIN + 2);
  localparam int unsigned HD_CW = $clog2(HOLD_MIN + 2);
  localparam logic [PW_CW-1:0] PW_CAP = PW_CW'(PW_MIN);
  localparam logic [SU_CW-1:0] SU_CAP = SU_CW'(SETUP_MIN);
  localparam logic [HD_CW-1:0] HD_LOAD = HD_CW'(HOLD_MIN - 1);

  logic [PW_CW-1:0] hi_cnt;
  logic [SU_CW-1:0] stab_q, stab_now;
  logic [HD_CW-1:0] hold_cnt;
  logic             hold_win;
  logic             viol_pulse, viol_setup, viol_hold;

  assign stab_now   = ctl_chg ? '0 : ((stab_q == SU_CAP) ? stab_q : stab_q + 1'b1);
  assign hold_win   = le_fall || (hold_cnt != '0);
  assign viol_pulse = rdy && le_fall && (hi_cnt < PW_CAP);
  assign viol_setup = rdy && le_rise && (stab_now < SU_CAP);
  assign viol_hold  = rdy && hold_win && ctl_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      stab_q    <= '0;
      hold_cnt  <= '0;
      err_pulse <= 1'b0;
      err_setup <= 1'b0;
      err_hold  <= 1'b0;
    end else begin
      hi_cnt <= le_s ? ((hi_cnt == PW_CAP) ? hi_cnt : hi_cnt + 1'b1) : '0;
      stab_q <= stab_now;
      if (le_fall)             hold_cnt <= HD_LOAD;
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      err_pulse <= viol_pulse || (err_pulse && !clr);
      err_setup <= viol_setup || (err_setup && !clr);
      err_hold  <= viol_hold  || (err_hold  && !clr);
    end
  end

  a_r7_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> err_pulse);
  a_r8_early_change: assert property (@(posedge clk) disable iff (!rst_n)
    viol_setup |=> err_setup);
  a_r9_late_change: assert property (@(posedge clk) disable iff (!rst_n)
    viol_hold |=> err_hold);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hold && !clr) |=> err_hold);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !viol_pulse) |=> !err_pulse);
endmodule

// File: rtl/attn_ctrl_latch.sv
module attn_ctrl_latch
  import attn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PW_MIN      = 1,
  parameter int unsigned SETUP_MIN   = 1,
  parameter int unsigned HOLD_MIN    = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  ctl_in,
  input  logic        le_in,
  input  logic [1:0]  psel,
  input  logic        clr_flags,
  output logic [4:0]  atten_q,
  output logic [4:0]  atten_db,
  output logic        err_pulse,
  output logic        err_setup,
  output logic        err_hold
);
  localparam int unsigned BUS_W = ATTN_W + 3;

  logic [BUS_W-1:0] raw_bus, sync_bus;
  logic             le_s, le_d;
  attn_t            ctl_s, ctl_d, state_q;
  logic [1:0]       psel_s;
  logic             rdy, le_rise, le_fall, ctl_chg;

  assign raw_bus = {le_in, psel, ctl_in};

  attn_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign {le_s, psel_s, ctl_s} = sync_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_d  <= 1'b0;
      ctl_d <= '0;
    end else begin
      le_d  <= le_s;
      ctl_d <= ctl_s;
    end
  end

  assign le_rise = le_s && !le_d;
  assign le_fall = !le_s && le_d;
  assign ctl_chg = (ctl_s != ctl_d);

  attn_state #(.SYNC_STAGES(SYNC_STAGES)) u_state (
    .clk(clk), .rst_n(rst_n), .le_s(le_s), .ctl_s(ctl_s),
    .psel_s(psel_s), .state_q(state_q), .rdy(rdy)
  );

  attn_timing #(.PW_MIN(PW_MIN), .SETUP_MIN(SETUP_MIN), .HOLD_MIN(HOLD_MIN)) u_timing (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .le_s(le_s), .le_rise(le_rise),
    .le_fall(le_fall), .ctl_chg(ctl_chg), .clr(clr_flags),
    .err_pulse(err_pulse), .err_setup(err_setup), .err_hold(err_hold)
  );

  assign atten_q  = state_q;
  assign atten_db = to_db(state_q);

  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |-> (atten_q == '0 && !err_pulse && !err_setup && !err_hold));
endmodule

// File: tb/tb_attn_ctrl_latch.sv
module tb_attn_ctrl_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ctl_in = '0;
  logic       le_in = 1'b0;
  logic [1:0] psel = '0;
  logic       clr_flags = 1'b0;
  logic [4:0] atten_q, atten_db;
  logic       err_pulse, err_setup, err_hold;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  attn_ctrl_latch #(.SYNC_STAGES(2), .PW_MIN(3), .SETUP_MIN(2), .HOLD_MIN(2)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .le_in(le_in), .psel(psel),
    .clr_flags(clr_flags), .atten_q(atten_q), .atten_db(atten_db),
    .err_pulse(err_pulse), .err_setup(err_setup), .err_hold(err_hold)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int p, input int s, input int h);
    chk({req, " pulse flag"}, int'(err_pulse), p);
    chk({req, " setup flag"}, int'(err_setup), s);
    chk({req, " hold flag"},  int'(err_hold),  h);
  endtask

  task automatic clear_flags();
    clr_flags = 1'b1; tick(1); clr_flags = 1'b0; tick(1);
  endtask

  // R1 and R5/R6: reset, then start-up state
  task automatic t_start(input logic [1:0] sel, input logic le, input logic [4:0] c,
                         input int exp, input string req);
    rst_n = 1'b0; psel = sel; le_in = le; ctl_in = c;
    tick(2);
    chk("R1 state in reset", int'(atten_q), 0);
    chk_flags("R1", 0, 0, 0);
    rst_n = 1'b1;
    tick(6);
    chk(req, int'(atten_q), exp);
    chk({req, " R4 dB"}, int'(atten_db), exp);
  endtask

  // R2: enable low, control changes ignored
  task automatic t_hold_low();
    ctl_in = 5'd7; tick(6);
    chk("R2 output held", int'(atten_q), 8);
  endtask

  // R3: transparent follow and latency
  task automatic t_transparent();
    ctl_in = 5'd22; tick(2);
    chk("R3 not yet updated", int'(atten_q), 3);
    tick(1);
    chk("R3 follows after three edges", int'(atten_q), 22);
    ctl_in = 5'd0; tick(3);
    chk("R3 follows to zero", int'(atten_q), 0);
    le_in = 1'b0; tick(6);
    clear_flags();
  endtask

  // R4 with exact-minimum setup, width and hold (R7/R8/R9 boundaries)
  task automatic t_latch_clean();
    ctl_in = 5'd5; tick(2);
    le_in = 1'b1; tick(1);
    ctl_in = 5'd19; tick(2);
    le_in = 1'b0; tick(2);
    ctl_in = 5'd1; tick(6);
    chk("R4 captured last high value", int'(atten_q), 19);
    chk("R4 dB of 16+2+1", int'(atten_db), 19);
    chk_flags("R7 R8 R9 boundary legal", 0, 0, 0);
  endtask

  // R7: short pulse
  task automatic t_short_pulse();
    ctl_in = 5'd9; tick(4);
    le_in = 1'b1; tick(1);
    le_in = 1'b0; tick(6);
    chk_flags("R7 short pulse", 1, 0, 0);
    chk("R4 captured in short pulse", int'(atten_q), 9);
    clear_flags();
    chk("R10 clear pulse flag", int'(err_pulse), 0);
  endtask

  // R8: data too close to rise
  task automatic t_setup_viol();
    ctl_in = 5'd12; tick(1);
    le_in = 1'b1; tick(3);
    le_in = 1'b0; tick(6);
    chk_flags("R8 setup short", 0, 1, 0);
    clear_flags();
    chk("R10 clear setup flag", int'(err_setup), 0);
  endtask

  // R9: data changes one cycle after fall
  task automatic t_hold_viol();
    ctl_in = 5'd30; tick(4);
    le_in = 1'b1; tick(3);
    le_in = 1'b0; tick(1);
    ctl_in = 5'd2; tick(6);
    chk_flags("R9 hold short", 0, 0, 1);
    chk("R9 state kept", int'(atten_q), 30);
    tick(4);
    chk("R10 flag sticky", int'(err_hold), 1);
    clear_flags();
    chk("R10 clear hold flag", int'(err_hold), 0);
  endtask

  // R10: clear on the same edge as a new hold violation
  task automatic t_collision();
    ctl_in = 5'd17; tick(4);
    le_in = 1'b1; tick(3);
    le_in = 1'b0; tick(1);
    ctl_in = 5'd4; tick(2);
    clr_flags = 1'b1; tick(1);
    clr_flags = 1'b0;
    chk("R10 set wins over clear", int'(err_hold), 1);
    tick(2);
    clear_flags();
    chk("R10 clear after collision", int'(err_hold), 0);
  endtask

  initial begin
    t_start(2'b00, 1'b0, 5'd5, 8, "R5 sel 00");
    t_hold_low();
    t_start(2'b01, 1'b0, 5'd5, 16, "R5 sel 01");
    t_start(2'b10, 1'b0, 5'd5, 31, "R5 sel 10");
    t_start(2'b11, 1'b0, 5'd13, 13, "R5 sel 11");
    t_start(2'b00, 1'b1, 5'd3, 3, "R6 sel ignored");
    t_transparent();
    t_latch_clean();
    t_short_pulse();
    t_setup_viol();
    t_hold_viol();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule